// File: doc/BRIEF.md
# Row/Column Register Write Decoder on an I2C Slave

This block is an I2C slave that sits between a host controller and a row/column addressed register file, such as the character and attribute store of an on-screen display. The host sends write transactions made of tagged address bytes and data bytes. The block turns each accepted data byte into a single register-file write with a 4-bit row, a 5-bit column, eight data bits and a latched font-page bit. It also answers a one-byte read that returns a status byte holding a reset-detect flag.

Each address byte carries its own tag, so one transaction can mix three framing styles. In the first style, a row byte and a column byte come before every data byte. In the second, the row is set once and column/data pairs follow. In the third, one column byte with the streaming tag is followed by any number of data bytes, and the column advances after each one. Once a transaction has entered streaming, it stays there until a STOP or a repeated START. SCL and SDA are sampled on the system clock. SDA is pulled low through `sda_oe`.

The write side is a valid/ready stream with a single entry. A write stays presented, with its fields frozen, until `wr_ready` is seen high together with `wr_valid`. I2C offers no back-pressure here, because clock stretching is not supported. A data byte that completes while the previous write is still waiting is therefore refused with a NAK. It is discarded and does not advance the column.

Top module: `osd_i2c_wrdec`

## Requirements
- R1: The slave acknowledges (pulls SDA low during the ninth SCL clock) the address byte 0x7A for writes and 0x7B for reads. It leaves SDA released for any other address, and it ignores the bytes of that transaction.
- R2: In the address phase, a byte with bit 7 = 1 is a row byte. Bits 3:0 give the row used by the writes that follow.
- R3: A byte with bit 7 = 0 and bit 6 = 0 is a column byte (column in bits 4:0). Exactly one data byte follows it, and the byte after that is again decoded as a row or column byte.
- R4: A column byte with bit 6 = 1 starts streaming. Every later byte is data, written at the current column, and the column then increments.
- R5: In streaming, a write at column 29 is followed by column 0 of the next row.
- R6: Bit 5 of a column byte is latched and presented as `wr_page` with every write until the next column byte.
- R7: In streaming, bytes with bit 7 or bit 6 set are still treated as data. There is no way out of streaming before STOP or repeated START.
- R8: A repeated START or a STOP returns the framing to the address phase.
- R9: A read addressed to 0x7B returns exactly one byte, the status byte. Any further clocks in the same read return 0xFF (SDA released). After reset the status byte reads 0x00.
- R10: A write at row 15, column 23 copies its data bit 1 into the flag. The flag is returned in bit 1 of the status byte (all other bits 0).
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and the row, column, data and page outputs hold. A data byte that completes in that state is NAKed, dropped, and does not advance the column.
- R12: After reset, `wr_valid` is low and SDA is released. SDA is also released whenever the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the pin |
| sda_i | input | 1 | I2C data line as seen on the pin |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| wr_valid | output | 1 | A register write is presented |
| wr_ready | input | 1 | Register file accepts the presented write |
| wr_row | output | 4 | Row of the write |
| wr_col | output | 5 | Column of the write |
| wr_data | output | 8 | Data byte of the write |
| wr_page | output | 1 | Latched font-page bit for the write |

## Verification
The bench builds the block with its default parameters: 4-bit rows, 30 columns, two synchroniser stages, the status byte at row 15 column 23 with the flag in bit 1, and device address 0x3D. The bus runs with eight system clocks per SCL half period. Starting a stream at column 27 brings the row wrap within three data bytes. Holding `wr_ready` low for a whole byte time makes the NAK-and-drop path of the single-entry write slot reachable.

// File: rtl/osd_wrdec_pkg.sv
package osd_wrdec_pkg;
  // Byte-level bus engine states
  typedef enum logic [2:0] {
    LK_IDLE, LK_RECV, LK_WAITF, LK_ACK, LK_SEND, LK_MACK
  } link_st_t;

  // Framing decoder states
  typedef enum logic [1:0] {
    FM_ADDR, FM_ONE, FM_STREAM
  } fmt_st_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/osd_i2c_sync.sv
module osd_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_ff[i] <= scl_ff[i-1];
        sda_ff[i] <= sda_ff[i-1];
      end
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s && !scl_q;
  assign scl_fall  = !scl_s && scl_q;
  assign start_det = scl_s && scl_q && sda_q && !sda_s;
  assign stop_det  = scl_s && scl_q && !sda_q && sda_s;
endmodule

// File: rtl/osd_i2c_link.sv
module osd_i2c_link
  import osd_wrdec_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] status_byte,
  input  logic              byte_ok,
  output logic              sda_oe,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_data
);
  link_st_t          st;
  logic [2:0]        cnt;
  logic [BYTE_W-1:0] shreg, txsh;
  logic              is_addr, rd_q, ack_q;

  assign byte_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= LK_IDLE; cnt <= '0; shreg <= '0; txsh <= '0;
      is_addr <= 1'b0; rd_q <= 1'b0; ack_q <= 1'b0;
      sda_oe <= 1'b0; byte_stb <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (byte_stb) ack_q <= byte_ok;
      if (start_det) begin
        st <= LK_RECV; cnt <= '0; is_addr <= 1'b1; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= LK_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          LK_RECV: if (scl_rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            if (cnt == 3'd7) begin
              cnt <= '0;
              st  <= LK_WAITF;
              if (is_addr) begin
                ack_q <= (shreg[BYTE_W-2:0] == DEV_ADDR);
                rd_q  <= sda_s;
              end else begin
                byte_stb <= 1'b1;
              end
            end else begin
              cnt <= cnt + 3'd1;
            end
          end
          LK_WAITF: if (scl_fall) begin
            sda_oe <= ack_q;
            st     <= LK_ACK;
          end
          LK_ACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            is_addr <= 1'b0;
            if (is_addr && !ack_q) begin
              st <= LK_IDLE;
            end else if (is_addr && rd_q) begin
              st     <= LK_SEND;
              txsh   <= status_byte;
              sda_oe <= !status_byte[BYTE_W-1];
              cnt    <= '0;
            end else begin
              st <= LK_RECV;
            end
          end
          LK_SEND: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= LK_MACK;
            end else begin
              txsh   <= {txsh[BYTE_W-2:0], 1'b0};
              sda_oe <= !txsh[BYTE_W-2];
              cnt    <= cnt + 3'd1;
            end
          end
          LK_MACK: if (scl_rise) st <= LK_IDLE;
          default: st <= LK_IDLE;
        endcase
      end
    end
  end

  AST_SDA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_IDLE) |-> !sda_oe); // R12
  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R1
  AST_RELEASE_FOR_MASTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_MACK) |-> !sda_oe); // R9
endmodule

// File: rtl/osd_frame_dec.sv
module osd_frame_dec
  import osd_wrdec_pkg::*;
#(
  parameter int ROW_W    = 4,
  parameter int COL_W    = 5,
  parameter int NUM_COLS = 30,
  parameter int STAT_ROW = 15,
  parameter int STAT_COL = 23,
  parameter int FLAG_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_reset,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              byte_ok,
  output logic [BYTE_W-1:0] status_byte,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_page
);
  fmt_st_t          fmt;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             page_q, flag_q, slot_busy, take;

  assign slot_busy = wr_valid && !wr_ready;
  assign byte_ok   = (fmt == FM_ADDR) || !slot_busy;
  assign take      = byte_stb && (fmt != FM_ADDR) && !slot_busy;

  always_comb begin
    status_byte           = '0;
    status_byte[FLAG_BIT] = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt <= FM_ADDR; row_q <= '0; col_q <= '0; page_q <= 1'b0; flag_q <= 1'b0;
      wr_valid <= 1'b0; wr_row <= '0; wr_col <= '0; wr_data <= '0; wr_page <= 1'b0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (take) begin
        wr_valid <= 1'b1;
        wr_row   <= row_q;
        wr_col   <= col_q;
        wr_data  <= byte_in;
        wr_page  <= page_q;
        if (row_q == ROW_W'(STAT_ROW) && col_q == COL_W'(STAT_COL))
          flag_q <= byte_in[FLAG_BIT];
      end
      if (txn_reset) begin
        fmt <= FM_ADDR;
      end else if (byte_stb) begin
        case (fmt)
          FM_ADDR:
            if (byte_in[7]) begin
              row_q <= byte_in[ROW_W-1:0];
            end else begin
              col_q  <= byte_in[COL_W-1:0];
              page_q <= byte_in[5];
              fmt    <= byte_in[6] ? FM_STREAM : FM_ONE;
            end
          FM_ONE: if (take) fmt <= FM_ADDR;
          FM_STREAM:
            if (take) begin
              if (col_q == COL_W'(NUM_COLS - 1)) begin
                col_q <= '0;
                row_q <= row_q + 1'b1;
              end else begin
                col_q <= col_q + 1'b1;
              end
            end
          default: fmt <= FM_ADDR;
        endcase
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_row) && $stable(wr_col)
                                 && $stable(wr_data) && $stable(wr_page))); // R11
  AST_STREAM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == FM_STREAM && !txn_reset) |=> (fmt == FM_STREAM)); // R7
endmodule

// File: rtl/osd_i2c_wrdec.sv
module osd_i2c_wrdec
  import osd_wrdec_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3D,
  parameter int         ROW_W       = 4,
  parameter int         NUM_COLS    = 30,
  parameter int         SYNC_STAGES = 2,
  parameter int         STAT_ROW    = 15,
  parameter int         STAT_COL    = 23,
  parameter int         FLAG_BIT    = 1,
  localparam int        COL_W       = $clog2(NUM_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_page
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              byte_stb, byte_ok;
  logic [BYTE_W-1:0] byte_data, status_byte;

  osd_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  osd_i2c_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .status_byte(status_byte), .byte_ok(byte_ok),
    .sda_oe(sda_oe), .byte_stb(byte_stb), .byte_data(byte_data)
  );

  osd_frame_dec #(
    .ROW_W(ROW_W), .COL_W(COL_W), .NUM_COLS(NUM_COLS),
    .STAT_ROW(STAT_ROW), .STAT_COL(STAT_COL), .FLAG_BIT(FLAG_BIT)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .txn_reset(start_det || stop_det),
    .byte_stb(byte_stb), .byte_in(byte_data), .byte_ok(byte_ok),
    .status_byte(status_byte),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_row(wr_row),
    .wr_col(wr_col), .wr_data(wr_data), .wr_page(wr_page)
  );
endmodule

// File: tb/test_osd_i2c_wrdec.sv
`timescale 1ns/1ps
module test_osd_i2c_wrdec;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wr_ready = 1'b1;
  logic sda_oe, wr_valid, wr_page;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic [7:0] wr_data;
  logic sda_bus;

  assign sda_bus = sda_m && !sda_oe;
  always #2 clk = !clk;

  osd_i2c_wrdec i_osd_i2c_wrdec (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .wr_page(wr_page)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // Accepted-write log, sampled mid-cycle
  logic [17:0] log_q [0:255];
  int log_n = 0;
  always @(negedge clk)
    if (rst_n && wr_valid && wr_ready) begin
      log_q[log_n[7:0]] = {wr_row, wr_col, wr_data, wr_page};
      log_n++;
    end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_write(input int idx, input int row, input int col,
                              input int data, input int page, input string req);
    logic [17:0] exp;
    exp = {row[3:0], col[4:0], data[7:0], page[0]};
    if (idx >= log_n) check(1'b0, req, log_n, idx + 1);
    else check(log_q[idx] == exp, req, int'(log_q[idx]), int'(exp));
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(HALF); scl_m = 1'b1; tick(HALF); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF / 2);
    b = sda_bus; tick(HALF / 2); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HALF); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF); scl_m = 1'b0; tick(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HALF); scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = !b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic nak);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      d[i] = b;
    end
    bit_out(nak);
  endtask

  task automatic t_reset();
    check(!wr_valid, "R12 wr_valid after reset", int'(wr_valid), 0);
    check(!sda_oe, "R12 sda released after reset", int'(sda_oe), 0);
  endtask

  task automatic read_status(input logic [7:0] exp, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    wbyte(8'h7B, ack);
    check(ack, "R1 read address acked", int'(ack), 1);
    rbyte(d, 1'b1);
    check(d == exp, req, int'(d), int'(exp));
    bus_stop();
  endtask

  task automatic t_addr();
    logic ack;
    int base;
    base = log_n;
    bus_start();
    wbyte(8'h70, ack);
    check(!ack, "R1 foreign address not acked", int'(ack), 0);
    wbyte(8'h81, ack); wbyte(8'h02, ack); wbyte(8'h33, ack);
    bus_stop();
    tick(4);
    check(log_n == base, "R1 foreign transaction writes nothing", log_n - base, 0);
    check(!sda_oe, "R12 idle keeps sda released", int'(sda_oe), 0);
  endtask

  task automatic t_explicit();
    logic ack;
    int base;
    base = log_n;
    bus_start();
    wbyte(8'h7A, ack);
    check(ack, "R1 write address acked", int'(ack), 1);
    wbyte(8'h83, ack); wbyte(8'h05, ack); wbyte(8'h41, ack);
    check(ack, "R3 data byte acked", int'(ack), 1);
    wbyte(8'h07, ack); wbyte(8'h42, ack);
    wbyte(8'h82, ack); wbyte(8'h23, ack); wbyte(8'h43, ack);
    bus_stop();
    tick(4);
    expect_write(base,     3, 5, 8'h41, 0, "R2 row+column write");
    expect_write(base + 1, 3, 7, 8'h42, 0, "R3 column-only write");
    expect_write(base + 2, 2, 3, 8'h43, 1, "R6 page bit from column byte");
    check(log_n - base == 3, "R3 one data byte per column", log_n - base, 3);
  endtask

  task automatic t_stream();
    logic ack;
    int base;
    base = log_n;
    bus_start();
    wbyte(8'h7A, ack);
    wbyte(8'h81, ack); wbyte(8'h7B, ack);
    wbyte(8'h10, ack); wbyte(8'h11, ack); wbyte(8'h12, ack);
    wbyte(8'h93, ack); wbyte(8'h54, ack);
    bus_stop();
    tick(4);
    expect_write(base,     1, 27, 8'h10, 1, "R4 first streamed write");
    expect_write(base + 1, 1, 28, 8'h11, 1, "R4 column increments");
    expect_write(base + 2, 1, 29, 8'h12, 1, "R6 page held in stream");
    expect_write(base + 3, 2, 0,  8'h93, 1, "R5 wrap to next row");
    expect_write(base + 4, 2, 1,  8'h54, 1, "R7 tagged byte stays data");
  endtask

  task automatic t_restart();
    logic ack;
    int base;
    base = log_n;
    bus_start();
    wbyte(8'h7A, ack);
    wbyte(8'h84, ack); wbyte(8'h42, ack); wbyte(8'h55, ack);
    bus_start();
    wbyte(8'h7A, ack);
    wbyte(8'h09, ack); wbyte(8'h66, ack);
    bus_stop();
    tick(4);
    expect_write(base,     4, 2, 8'h55, 0, "R4 stream before restart");
    expect_write(base + 1, 4, 9, 8'h66, 0, "R8 restart returns to address phase");
    check(log_n - base == 2, "R8 write count", log_n - base, 2);
  endtask

  task automatic t_flag();
    logic ack;
    logic [7:0] d;
    int base;
    base = log_n;
    bus_start();
    wbyte(8'h7A, ack);
    wbyte(8'h8F, ack); wbyte(8'h17, ack); wbyte(8'h02, ack);
    bus_stop();
    tick(4);
    expect_write(base, 15, 23, 8'h02, 0, "R10 status write forwarded");
    read_status(8'h02, "R10 flag reads back in bit 1");
    bus_start();
    wbyte(8'h7B, ack);
    rbyte(d, 1'b0);
    check(d == 8'h02, "R9 first read byte", int'(d), 8'h02);
    rbyte(d, 1'b1);
    check(d == 8'hFF, "R9 only one byte returned", int'(d), 8'hFF);
    bus_stop();
  endtask

  task automatic t_backpressure();
    logic ack;
    int base;
    base = log_n;
    wr_ready = 1'b0;
    bus_start();
    wbyte(8'h7A, ack);
    wbyte(8'h80, ack); wbyte(8'h40, ack); wbyte(8'hA1, ack);
    check(ack, "R11 byte into free slot acked", int'(ack), 1);
    tick(3 * HALF);
    check(wr_valid && wr_data == 8'hA1 && wr_col == 5'd0,
          "R11 write held while not ready", int'(wr_data), 8'hA1);
    wbyte(8'hA2, ack);
    check(!ack, "R11 byte into busy slot NAKed", int'(ack), 0);
    check(wr_data == 8'hA1, "R11 held data unchanged", int'(wr_data), 8'hA1);
    wr_ready = 1'b1;
    tick(2);
    check(!wr_valid, "R11 slot drains on ready", int'(wr_valid), 0);
    wbyte(8'hA3, ack);
    check(ack, "R11 byte after drain acked", int'(ack), 1);
    bus_stop();
    tick(4);
    expect_write(base,     0, 0, 8'hA1, 0, "R11 held write delivered");
    expect_write(base + 1, 0, 1, 8'hA3, 0, "R11 dropped byte did not advance column");
    check(log_n - base == 2, "R11 dropped byte not written", log_n - base, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    read_status(8'h00, "R9 status after reset");
    t_addr();
    t_explicit();
    t_stream();
    t_restart();
    t_flag();
    t_backpressure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule